// File: doc/BRIEF.md
# SPI ADC Command Transaction Engine

This block is the controller side of a serial link to a delta-sigma converter. Each host request starts one framed exchange. The engine builds a command byte from a device address, a register or fast-command code and a command type. It shifts that byte out on the data-out line. In the same eight clocks it captures the status byte that the converter returns. After the command byte, the engine does one of three things, depending on the command type:

- It sends up to four write bytes.
- It collects up to four read bytes and, if asked, a two-byte CRC trailer.
- It sends nothing more, for a fast command.

When chip select is released, the engine reports three results. The first is the captured status with its three flags decoded. The second is whether the converter echoed the expected address. The third, for reads with CRC on, is whether the received CRC matches one computed locally over the status byte and the data bytes.

The host side is a one-cycle request strobe with the command fields and a packed write word. The response side has a one-cycle `done` pulse and result outputs. The results stay unchanged until the next request is accepted.

Top module: `adc_spi_xact`

## Requirements
- R1: The first byte on `mosi` is {req_dev[1:0], req_code[3:0], req_kind[1:0]} from bit 7 down. Kind 00 is fast command, 01 is single read, 10 is incremental write and 11 is incremental read.
- R2: A fast command (kind 00) frames exactly one byte (8 SCLK pulses), whatever `req_len` and `req_crc_en` hold.
- R3: A write (kind 10) sends `req_len`+1 data bytes after the command byte. They are taken from `req_wdata`, most significant byte first.
- R4: A read (kind 01 or 11) receives `req_len`+1 data bytes and sends 0x00 on `mosi` while doing so. They appear in `rsp_rdata` right-aligned, with the first received byte most significant and the unused upper bytes at zero.
- R5: The byte received during the command byte appears on `rsp_status`. `flag_ready`, `flag_cfg_err` and `flag_por` are the inverse of status bits 2, 1 and 0 respectively, because those bits are active low.
- R6: `rsp_ack_err` is 1 exactly when status bits[5:3] differ from {req_dev[1:0], ~req_dev[0]}.
- R7: On a read with `req_crc_en` = 1, two CRC bytes follow the data, most significant first. `rsp_crc_err` is 1 exactly when they differ from the CRC-16 with polynomial 0x8005 and initial value 0, computed over the status byte and then the data bytes. Without a read with CRC enabled, no CRC bytes are framed and `rsp_crc_err` is 0.
- R8: The link runs in SPI mode 0. SCLK idles low, `mosi` changes only while SCLK is low, and `miso` is sampled on the rising edge. Each bit is sent most significant first. `cs_n` falls 2*SCLK_HALF clocks before the first rising SCLK edge and rises 2*SCLK_HALF clocks after the last falling edge.
- R9: `busy` is high from the cycle after a request is accepted until `done` pulses. `done` lasts one cycle and is never high together with `busy`. A request raised while busy is ignored.
- R10: After reset, `cs_n` is 1 and `sclk`, `busy` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | One-cycle request strobe, taken only when idle |
| req_kind | input | 2 | Command type |
| req_dev | input | 2 | Device address |
| req_code | input | 4 | Register address or fast-command code |
| req_len | input | LEN_W | Data byte count minus one |
| req_crc_en | input | 1 | Expect a CRC trailer on reads |
| req_wdata | input | 8*MAX_BYTES | Write bytes, first byte in the top byte |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rsp_status | output | 8 | Captured status byte |
| rsp_rdata | output | 8*MAX_BYTES | Read bytes, right-aligned |
| rsp_ack_err | output | 1 | Address echo mismatch |
| rsp_crc_err | output | 1 | Read CRC mismatch |
| flag_ready | output | 1 | Conversion data ready (decoded) |
| flag_cfg_err | output | 1 | Configuration CRC error (decoded) |
| flag_por | output | 1 | Power-on reset seen (decoded) |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to converter |
| miso | input | 1 | Serial data from converter |
| cs_n | output | 1 | Chip select, active low |

## Verification
The two error outputs depend entirely on what the far end returns, so no host-side input can force them. The bench therefore carries a converter model whose reply frame is loaded before each request. The loaded frame can hold a status byte with a deliberately wrong address echo, or a correct CRC trailer with one bit flipped. The second hard case is a request that arrives in the middle of a frame. The bench raises a conflicting strobe while a read is under way, then confirms that only one chip-select frame and one completion occurred.

// File: rtl/adc_xact_pkg.sv
package adc_xact_pkg;

    typedef enum logic [1:0] {
        CMD_FAST   = 2'b00,
        CMD_RD_ONE = 2'b01,
        CMD_WR_INC = 2'b10,
        CMD_RD_INC = 2'b11
    } cmd_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_XFER,
        ST_TRAIL,
        ST_DONE
    } xact_state_e;

    localparam logic [15:0] CRC_POLY = 16'h8005;

    // One byte through a CRC-16 with MSB-first feedback.
    function automatic logic [15:0] crc16_byte(input logic [15:0] crc_in,
                                               input logic [7:0]  data);
        logic [15:0] c;
        logic        fb;
        c = crc_in;
        for (int i = 7; i >= 0; i--) begin
            fb = c[15] ^ data[i];
            c  = {c[14:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

endpackage

// File: rtl/adc_sclk_timer.sv
module adc_sclk_timer #(
    parameter int HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run)             cnt_d = '0;
        else if (cnt_q == LAST) cnt_d = '0;
        else                  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = run && (cnt_q == LAST);

    // R8
    tick_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt_q == '0));

endmodule

// File: rtl/adc_crc16_acc.sv
module adc_crc16_acc
    import adc_xact_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        feed,
    input  logic [7:0]  byte_in,
    output logic [15:0] crc
);
    logic [15:0] crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (clear)     crc_d = '0;
        else if (feed) crc_d = crc16_byte(crc_q, byte_in);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= '0;
        else        crc_q <= crc_d;
    end

    assign crc = crc_q;

    // R7
    crc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (crc_q == 16'h0000));

endmodule

// File: rtl/adc_spi_xact.sv
module adc_spi_xact
    import adc_xact_pkg::*;
#(
    parameter int MAX_BYTES = 4,
    parameter int SCLK_HALF = 4,
    localparam int LEN_W  = $clog2(MAX_BYTES),
    localparam int DATA_W = 8 * MAX_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [1:0]        req_dev,
    input  logic [3:0]        req_code,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_crc_en,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [7:0]        rsp_status,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_ack_err,
    output logic              rsp_crc_err,
    output logic              flag_ready,
    output logic              flag_cfg_err,
    output logic              flag_por,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_n
);
    localparam int IDX_W = $clog2(MAX_BYTES + 4);

    typedef struct packed {
        xact_state_e        st;
        logic               ph;
        logic [2:0]         bitc;
        logic [IDX_W-1:0]   bidx;
        logic [IDX_W-1:0]   last_idx;
        logic [IDX_W-1:0]   ndata;
        logic [1:0]         kind;
        logic [1:0]         dev;
        logic               crc_en;
        logic [7:0]         tx_sh;
        logic [DATA_W-1:0]  wr_sh;
        logic [7:0]         rx_sh;
        logic [7:0]         status;
        logic [DATA_W-1:0]  rd;
        logic [15:0]        crc_rx;
        logic               ack_err;
        logic               crc_err;
    } xact_regs_t;

    xact_regs_t d, q;

    logic        tick;
    logic        run;
    logic        crc_clear;
    logic        crc_feed;
    logic [15:0] crc_calc;

    assign run = (q.st == ST_LEAD) || (q.st == ST_XFER) || (q.st == ST_TRAIL);

    adc_sclk_timer #(.HALF(SCLK_HALF)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    adc_crc16_acc u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (crc_clear),
        .feed    (crc_feed),
        .byte_in (q.rx_sh),
        .crc     (crc_calc)
    );

    always_comb begin
        d         = q;
        crc_clear = 1'b0;
        crc_feed  = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.st       = ST_LEAD;
                    d.kind     = req_kind;
                    d.dev      = req_dev;
                    d.ndata    = (req_kind == CMD_FAST) ? '0
                                 : IDX_W'(req_len) + IDX_W'(1);
                    d.crc_en   = req_crc_en && req_kind[0];
                    d.last_idx = d.ndata + ((req_crc_en && req_kind[0]) ? IDX_W'(2) : '0);
                    d.tx_sh    = {req_dev, req_code, req_kind};
                    d.wr_sh    = req_wdata;
                    d.rx_sh    = '0;
                    d.rd       = '0;
                    d.status   = '0;
                    d.crc_rx   = '0;
                    d.ack_err  = 1'b0;
                    d.crc_err  = 1'b0;
                    d.bitc     = '0;
                    d.bidx     = '0;
                    d.ph       = 1'b0;
                    crc_clear  = 1'b1;
                end
            end
            ST_LEAD: begin
                if (tick) d.st = ST_XFER;
            end
            ST_XFER: begin
                if (tick) begin
                    if (!q.ph) begin
                        d.ph    = 1'b1;
                        d.rx_sh = {q.rx_sh[6:0], miso};
                    end else begin
                        d.ph = 1'b0;
                        if (q.bitc == 3'd7) begin
                            d.bitc = '0;
                            if (q.bidx == '0)
                                d.status = q.rx_sh;
                            else if (q.bidx <= q.ndata)
                                d.rd = {q.rd[DATA_W-9:0], q.rx_sh};
                            else
                                d.crc_rx = {q.crc_rx[7:0], q.rx_sh};
                            crc_feed = (q.bidx <= q.ndata);
                            if (q.bidx == q.last_idx) begin
                                d.st = ST_TRAIL;
                            end else begin
                                d.bidx = q.bidx + 1'b1;
                                if (q.kind == CMD_WR_INC) begin
                                    d.tx_sh = q.wr_sh[DATA_W-1 -: 8];
                                    d.wr_sh = {q.wr_sh[DATA_W-9:0], 8'h00};
                                end else begin
                                    d.tx_sh = 8'h00;
                                end
                            end
                        end else begin
                            d.bitc  = q.bitc + 1'b1;
                            d.tx_sh = {q.tx_sh[6:0], 1'b0};
                        end
                    end
                end
            end
            ST_TRAIL: begin
                if (tick) begin
                    if (!q.ph) begin
                        d.ph = 1'b1;
                    end else begin
                        d.ph      = 1'b0;
                        d.st      = ST_DONE;
                        d.ack_err = (q.status[5:3] != {q.dev, ~q.dev[0]});
                        d.crc_err = q.crc_en && (q.crc_rx != crc_calc);
                    end
                end
            end
            ST_DONE: d.st = ST_IDLE;
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign busy         = run;
    assign done         = (q.st == ST_DONE);
    assign cs_n         = !run;
    assign sclk         = (q.st == ST_XFER) && q.ph;
    assign mosi         = (q.st == ST_XFER) && q.tx_sh[7];
    assign rsp_status   = q.status;
    assign rsp_rdata    = q.rd;
    assign rsp_ack_err  = q.ack_err;
    assign rsp_crc_err  = q.crc_err;
    assign flag_ready   = ~q.status[2];
    assign flag_cfg_err = ~q.status[1];
    assign flag_por     = ~q.status[0];

    // R9
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    sclk_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !cs_n);

    // R8
    mosi_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $stable(mosi));

    // R2
    fast_single_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_XFER && q.kind == CMD_FAST) |-> (q.bidx == '0));

    // R7
    crc_err_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rsp_crc_err) |-> q.kind[0]);

endmodule

// File: tb/adc_spi_xact_bench.sv
module adc_spi_xact_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;

    typedef struct packed {
        logic [63:0] mosi;
        logic [3:0]  nbytes;
        logic [7:0]  status;
        logic [31:0] rd;
        logic        ack;
        logic        crc;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = '0;
    logic [1:0]  req_dev = '0;
    logic [3:0]  req_code = '0;
    logic [1:0]  req_len = '0;
    logic        req_crc_en = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        busy, done, ack_err, crc_err, f_rdy, f_cfg, f_por;
    logic [7:0]  status;
    logic [31:0] rdata;
    logic        sclk, mosi, cs_n;
    logic        miso = 1'b0;

    int nvec = 0;
    int nfail = 0;
    int ntx = 0;
    int csf_count = 0;
    int sbit = 0;
    logic [63:0] slv_tx = '0;
    logic [63:0] slv_rx = '0;
    time t_csf = 0, t_fall = 0, lead_t = 0, trail_t = 0;
    exp_t expq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_spi_xact #(.MAX_BYTES(4), .SCLK_HALF(HALF)) u_adc_spi_xact (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_dev(req_dev), .req_code(req_code), .req_len(req_len),
        .req_crc_en(req_crc_en), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rsp_status(status), .rsp_rdata(rdata), .rsp_ack_err(ack_err),
        .rsp_crc_err(crc_err), .flag_ready(f_rdy), .flag_cfg_err(f_cfg),
        .flag_por(f_por), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    function automatic logic [15:0] ref_crc(input logic [63:0] msg, input int n);
        logic [15:0] c = 16'h0000;
        for (int j = 0; j < n; j++) begin
            c = c ^ {msg[63-8*j -: 8], 8'h00};
            for (int k = 0; k < 8; k++)
                c = c[15] ? ({c[14:0], 1'b0} ^ 16'h8005) : {c[14:0], 1'b0};
        end
        return c;
    endfunction

    function automatic logic [7:0] good_status(input logic [1:0] dev, input logic [2:0] fl);
        return {2'b00, dev, ~dev[0], fl};
    endfunction

    // Converter model: drives miso after each falling edge, samples mosi on rising edges
    initial forever begin
        @(negedge cs_n);
        csf_count++;
        t_csf  = $time;
        slv_rx = '0;
        sbit   = 0;
        miso   = slv_tx[63];
        while (1) begin
            @(posedge sclk or posedge cs_n);
            if (cs_n) begin
                trail_t = $time - t_fall;
                break;
            end
            if (sbit == 0) lead_t = $time - t_csf;
            if (sbit < 64) slv_rx[63-sbit] = mosi;
            @(negedge sclk);
            t_fall = $time;
            sbit++;
            if (sbit < 64) miso = slv_tx[63-sbit];
        end
    end

    // Scoreboard monitor
    initial forever begin
        exp_t e;
        @(negedge clk);
        if (done) begin
            if (expq.size() == 0) begin
                check(1'b0, "R9", "unexpected completion", 64'd1, 64'd0);
            end else begin
                e = expq.pop_front();
                check(slv_rx == e.mosi, "R1/R3", "mosi bytes", slv_rx, e.mosi);
                check(sbit == 8*int'(e.nbytes), "R2/R7", "sclk pulses", 64'(sbit), 64'(8*int'(e.nbytes)));
                check(status == e.status, "R5", "status", 64'(status), 64'(e.status));
                check({f_rdy, f_cfg, f_por} == ~e.status[2:0], "R5", "flags",
                      64'({f_rdy, f_cfg, f_por}), 64'(~e.status[2:0]));
                check(rdata == e.rd, "R4", "read data", 64'(rdata), 64'(e.rd));
                check(ack_err == e.ack, "R6", "ack error", 64'(ack_err), 64'(e.ack));
                check(crc_err == e.crc, "R7", "crc error", 64'(crc_err), 64'(e.crc));
                check(lead_t == 2*HALF*CLK_PERIOD, "R8", "cs lead time",
                      64'(lead_t), 64'(2*HALF*CLK_PERIOD));
                check(trail_t == 2*HALF*CLK_PERIOD, "R8", "cs trail time",
                      64'(trail_t), 64'(2*HALF*CLK_PERIOD));
                check(!busy, "R9", "busy during done", 64'(busy), 64'd0);
            end
        end
    end

    task automatic xact(input logic [1:0] kind, input logic [1:0] dev,
                        input logic [3:0] code, input int len, input bit crc_en,
                        input logic [31:0] wdata, input logic [7:0] st,
                        input logic [31:0] rdat, input bit corrupt, input bit poke);
        exp_t e;
        int   nd;
        bit   rd_op;
        bit   use_crc;
        logic [15:0] c;
        logic [31:0] mask;
        rd_op   = kind[0];
        nd      = (kind == 2'b00) ? 0 : len;
        use_crc = rd_op && crc_en;
        mask    = (len == 4) ? 32'hFFFF_FFFF : ((32'd1 << (8*len)) - 1);
        slv_tx  = '0;
        slv_tx[63:56] = st;
        e        = '0;
        e.mosi[63:56] = {dev, code, kind};
        if (rd_op) begin
            for (int j = 0; j < len; j++)
                slv_tx[63-8*(j+1) -: 8] = rdat[8*(len-1-j) +: 8];
            e.rd = rdat & mask;
        end
        if (kind == 2'b10)
            for (int j = 0; j < len; j++)
                e.mosi[63-8*(j+1) -: 8] = wdata[31-8*j -: 8];
        if (use_crc) begin
            c = ref_crc(slv_tx, 1 + len) ^ (corrupt ? 16'h0001 : 16'h0000);
            slv_tx[63-8*(1+len) -: 8] = c[15:8];
            slv_tx[63-8*(2+len) -: 8] = c[7:0];
        end
        e.nbytes = 4'(1 + nd + (use_crc ? 2 : 0));
        e.status = st;
        e.ack    = (st[5:3] != {dev, ~dev[0]});
        e.crc    = use_crc && corrupt;
        expq.push_back(e);
        ntx++;
        @(negedge clk);
        req_kind   = kind;
        req_dev    = dev;
        req_code   = code;
        req_len    = 2'(len - 1);
        req_crc_en = crc_en;
        req_wdata  = wdata;
        req_valid  = 1'b1;
        @(negedge clk);
        req_valid  = 1'b0;
        check(busy, "R9", "busy after accept", 64'(busy), 64'd1);
        if (poke) begin
            repeat (60) @(negedge clk);
            req_kind  = 2'b00;
            req_dev   = ~dev;
            req_code  = 4'hE;
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (!done) @(negedge clk);
        repeat (4) @(negedge clk);
        check(status == st && rdata == e.rd, "R9", "results held after done",
              {status, rdata}, {st, e.rd});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check(cs_n === 1'b1, "R10", "cs_n in reset", 64'(cs_n), 64'd1);
        check(sclk === 1'b0 && busy === 1'b0 && done === 1'b0, "R10", "sclk/busy/done in reset",
              64'({sclk, busy, done}), 64'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(cs_n === 1'b1 && sclk === 1'b0, "R10", "idle after reset", 64'({cs_n, sclk}), 64'h2);

        // R1 R2: fast start-conversion, good echo, data-ready asserted (bit2 low)
        xact(2'b00, 2'b01, 4'hA, 1, 1'b0, 32'h0, good_status(2'b01, 3'b011), 32'h0, 1'b0, 1'b0);
        // R6: fast reset with a wrong echo
        xact(2'b00, 2'b10, 4'hE, 1, 1'b0, 32'h0, 8'h3F, 32'h0, 1'b0, 1'b0);
        // R2: fast with len and crc_en set still one byte
        xact(2'b00, 2'b11, 4'hB, 4, 1'b1, 32'hFFFF_FFFF, good_status(2'b11, 3'b110), 32'h0, 1'b0, 1'b0);
        // R3: one-byte write
        xact(2'b10, 2'b00, 4'hD, 1, 1'b0, 32'hA500_0000, good_status(2'b00, 3'b111), 32'h0, 1'b0, 1'b0);
        // R3: four-byte write; crc_en has no effect on writes (R7)
        xact(2'b10, 2'b11, 4'h1, 4, 1'b1, 32'hC35A_0F81, good_status(2'b11, 3'b101), 32'h0, 1'b0, 1'b0);
        // R4: three-byte incremental read without CRC
        xact(2'b11, 2'b01, 4'h6, 3, 1'b0, 32'h0, good_status(2'b01, 3'b010), 32'h00AB_CDEF, 1'b0, 1'b0);
        // R7: four-byte single read with a correct CRC
        xact(2'b01, 2'b00, 4'h0, 4, 1'b1, 32'h0, good_status(2'b00, 3'b011), 32'h8123_4567, 1'b0, 1'b0);
        // R7: one-byte read with a corrupted CRC
        xact(2'b01, 2'b10, 4'h5, 1, 1'b1, 32'h0, good_status(2'b10, 3'b001), 32'h0000_00E7, 1'b1, 1'b0);
        // R6 R7: bad echo but valid CRC over the status byte as sent
        xact(2'b11, 2'b01, 4'h3, 2, 1'b1, 32'h0, 8'h07, 32'h0000_1234, 1'b0, 1'b0);
        // R9: request raised mid-frame is ignored
        xact(2'b11, 2'b10, 4'h9, 3, 1'b1, 32'h0, good_status(2'b10, 3'b100), 32'h0055_AA01, 1'b0, 1'b1);
        repeat (200) @(negedge clk);
        check(csf_count == ntx, "R9", "frame count", 64'(csf_count), 64'(ntx));
        check(expq.size() == 0, "R9", "pending completions", 64'(expq.size()), 64'd0);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule